// File: doc/BRIEF.md
# Frequency Sweep Sequencer with Settling Delay

This block steers a stepped-frequency measurement. It holds a configuration file with four entries: the start frequency code, the step code, the number of steps, and the settling word. It accepts three commands: begin a sweep, advance one step, and re-measure the current point. Every accepted command sets the excitation frequency code and restarts a settling delay. The delay counts excitation periods, which arrive as strobes on `exc_tick`. When the delay has run out, the block opens a sample-collection window. The window closes after a fixed number of sample strobes. At that moment the block latches the real and imaginary results offered by an external transform unit, and it raises a point-done flag.

The frequency code is an unsigned 24-bit word. One step adds the step code to it, modulo 2^24. The step code is the step frequency divided by a quarter of the master clock, times 2^27. For example, a 10 Hz step at a 16 MHz clock gives 0x00014F. The sweep ends when the point index reaches the programmed number of steps and that point has been measured. After that, only a new begin command moves the sweep on. The configuration entries keep their contents through `rst`; only the sequencing state is cleared.

Top module: `freq_sweep_seq`

## Requirements
- R1: While and after `rst`, `freq_code` = 0, `point_idx` = 0, and `settling`, `sampling`, `point_done` and `sweep_done` are all 0.
- R2: A begin command (`cmd_code` = 1 with `cmd_valid`) loads `freq_code` with the start entry, sets `point_idx` to 0, clears both done flags and enters settling. It is accepted in any state.
- R3: A step command (`cmd_code` = 2) adds the step entry to `freq_code` modulo 2^24 and adds 1 to `point_idx`, then restarts settling. Before the first begin command after reset, a step command is ignored.
- R4: The settling word uses these fields: bits 8..0 give the count N, and bits 10..9 give the multiplier (00 = ×1, 01 = ×2, 10 = ×1, 11 = ×4). Bits 15..11 are ignored. `sampling` rises only after N×multiplier `exc_tick` pulses have been counted while `settling` is high. With a count of 0, sampling begins without any tick.
- R5: Only bits 8..0 of the step-count entry are used. Bits 15..9 are ignored.
- R6: Sampling ends on the 1024th `smp_valid` pulse counted while `sampling` is high. In that cycle, `dft_re` and `dft_im` are captured into `res_re` and `res_im`, and `point_done` is set.
- R7: When a point finishes with `point_idx` ≥ the step count, `sweep_done` is set. While `point_idx` ≥ the step count, a step command leaves `freq_code`, `point_idx` and the flags unchanged.
- R8: A repeat command (`cmd_code` = 3), accepted after a begin, keeps `freq_code` and `point_idx` and restarts settling and sampling.
- R9: The four configuration entries are not changed by `rst`. They are written with `cfg_we`, where `cfg_sel` selects 0 = start, 1 = step, 2 = step count, 3 = settling word.
- R10: `settling` and `sampling` are never high together. `exc_tick` and `smp_valid` have no effect outside their own phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencing state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration entry select |
| cfg_wdata | input | 24 | Configuration write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 1 begin, 2 step, 3 repeat |
| exc_tick | input | 1 | One pulse per excitation period |
| smp_valid | input | 1 | One pulse per collected sample |
| dft_re | input | 16 | Real result from the transform unit |
| dft_im | input | 16 | Imaginary result from the transform unit |
| freq_code | output | 24 | Current excitation frequency code |
| point_idx | output | 9 | Index of the current point |
| settling | output | 1 | Settling delay running |
| sampling | output | 1 | Sample window open |
| point_done | output | 1 | Current point measured |
| sweep_done | output | 1 | Last point measured |
| res_re | output | 16 | Latched real result |
| res_im | output | 16 | Latched imaginary result |

## Verification
A command can arrive in the same cycle as the tick that ends the settling delay, or as the last sample of a window. In that case the command's restart must win: the counters clear and the block returns to settling. The bench sends repeat and step commands while the window is open and while ticks are active, then checks that settling is high again and that the full programmed delay elapses once more. The checker also requires, in every cycle, that the settling and sampling phases never overlap and that each rise of `point_done` follows an open window.

// File: rtl/freq_sweep_pkg.sv
package freq_sweep_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_BEGIN  = 2'd1,
    CMD_STEP   = 2'd2,
    CMD_REPEAT = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_SAMPLE = 2'd2,
    PH_DONE   = 2'd3
  } phase_e;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_STEP  = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;
  localparam logic [1:0] SEL_SETTL = 2'd3;
endpackage

// File: rtl/sweep_cfg_regs.sv
module sweep_cfg_regs
  import freq_sweep_pkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [FREQ_W-1:0] wdata,
  output logic [FREQ_W-1:0] start_code,
  output logic [FREQ_W-1:0] step_code,
  output logic [CNT_W-1:0]  step_count,
  output logic [CNT_W-1:0]  settle_n,
  output logic [1:0]        settle_mul
);
  // Configuration is deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (we) begin
      unique case (sel)
        SEL_START: start_code <= wdata;
        SEL_STEP:  step_code  <= wdata;
        SEL_COUNT: step_count <= wdata[CNT_W-1:0];
        SEL_SETTL: begin
          settle_n   <= wdata[CNT_W-1:0];
          settle_mul <= wdata[CNT_W+1:CNT_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sweep_code_stepper.sv
module sweep_code_stepper #(
  parameter int FREQ_W = 24,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [FREQ_W-1:0] start_code,
  input  logic [FREQ_W-1:0] step_code,
  output logic [FREQ_W-1:0] freq_code,
  output logic [CNT_W-1:0]  point_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      freq_code <= '0;
      point_idx <= '0;
    end else if (load) begin
      freq_code <= start_code;
      point_idx <= '0;
    end else if (step) begin
      freq_code <= freq_code + step_code;
      point_idx <= point_idx + 1'b1;
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 9,
  localparam int TGT_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] n,
  input  logic [1:0]       mul,
  output logic             expired
);
  logic [TGT_W-1:0] target;
  logic [TGT_W-1:0] count;

  // Multiplier code 10 falls back to x1.
  always_comb begin
    unique case (mul)
      2'b01:   target = {1'b0, n, 1'b0};
      2'b11:   target = {n, 2'b00};
      default: target = {2'b00, n};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (enable && tick && (count < target)) begin
      count <= count + 1'b1;
    end
  end

  assign expired = enable && (count >= target);
endmodule

// File: rtl/sample_window.sv
module sample_window #(
  parameter int NSAMP = 1024,
  localparam int SW = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  input  logic valid,
  output logic last
);
  localparam logic [SW-1:0] LAST_IDX = SW'(NSAMP - 1);
  logic [SW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (enable && valid) begin
      count <= (count == LAST_IDX) ? '0 : count + 1'b1;
    end
  end

  assign last = enable && valid && (count == LAST_IDX);
endmodule

// File: rtl/freq_sweep_seq.sv
module freq_sweep_seq
  import freq_sweep_pkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int CNT_W  = 9,
  parameter int RES_W  = 16,
  parameter int NSAMP  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [FREQ_W-1:0] cfg_wdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic              exc_tick,
  input  logic              smp_valid,
  input  logic [RES_W-1:0]  dft_re,
  input  logic [RES_W-1:0]  dft_im,
  output logic [FREQ_W-1:0] freq_code,
  output logic [CNT_W-1:0]  point_idx,
  output logic              settling,
  output logic              sampling,
  output logic              point_done,
  output logic              sweep_done,
  output logic [RES_W-1:0]  res_re,
  output logic [RES_W-1:0]  res_im
);
  logic [FREQ_W-1:0] start_code, step_code;
  logic [CNT_W-1:0]  step_count, settle_n;
  logic [1:0]        settle_mul;
  phase_e            phase;
  logic              go_begin, go_step, go_repeat, restart;
  logic              at_last, delay_over, window_last;

  sweep_cfg_regs #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .start_code(start_code), .step_code(step_code), .step_count(step_count),
    .settle_n(settle_n), .settle_mul(settle_mul)
  );

  assign at_last   = (point_idx >= step_count);
  assign go_begin  = cmd_valid && (cmd_code == CMD_BEGIN);
  assign go_step   = cmd_valid && (cmd_code == CMD_STEP) &&
                     (phase != PH_IDLE) && !at_last;
  assign go_repeat = cmd_valid && (cmd_code == CMD_REPEAT) && (phase != PH_IDLE);
  assign restart   = go_begin || go_step || go_repeat;

  sweep_code_stepper #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_code (
    .clk(clk), .rst(rst), .load(go_begin), .step(go_step),
    .start_code(start_code), .step_code(step_code),
    .freq_code(freq_code), .point_idx(point_idx)
  );

  settle_timer #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst(rst), .clear(restart), .enable(phase == PH_SETTLE),
    .tick(exc_tick), .n(settle_n), .mul(settle_mul), .expired(delay_over)
  );

  sample_window #(.NSAMP(NSAMP)) u_window (
    .clk(clk), .rst(rst), .clear(restart), .enable(phase == PH_SAMPLE),
    .valid(smp_valid), .last(window_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      point_done <= 1'b0;
      sweep_done <= 1'b0;
      res_re     <= '0;
      res_im     <= '0;
    end else if (restart) begin
      phase      <= PH_SETTLE;
      point_done <= 1'b0;
      sweep_done <= 1'b0;
    end else begin
      unique case (phase)
        PH_SETTLE: if (delay_over) phase <= PH_SAMPLE;
        PH_SAMPLE: if (window_last) begin
          phase      <= PH_DONE;
          point_done <= 1'b1;
          sweep_done <= at_last;
          res_re     <= dft_re;
          res_im     <= dft_im;
        end
        default: ;
      endcase
    end
  end

  assign settling = (phase == PH_SETTLE);
  assign sampling = (phase == PH_SAMPLE);
endmodule

// File: rtl/freq_sweep_chk.sv
module freq_sweep_chk #(
  parameter int FREQ_W = 24,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_code,
  input logic [FREQ_W-1:0] freq_code,
  input logic [CNT_W-1:0]  point_idx,
  input logic              settling,
  input logic              sampling,
  input logic              point_done,
  input logic              sweep_done
);
  // R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(settling && sampling));

  // R6
  done_after_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(point_done) |-> $past(sampling));

  // R4
  window_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sampling) |-> $past(settling));

  // R7
  sweep_implies_point_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> point_done);

  // R7
  step_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (sweep_done && cmd_valid && cmd_code == 2'd2) |=>
      ($stable(freq_code) && $stable(point_idx) && point_done));

  // R8
  repeat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 2'd3 && (settling || sampling || point_done)) |=>
      (settling && $stable(freq_code) && $stable(point_idx)));
endmodule

bind freq_sweep_seq freq_sweep_chk #(.FREQ_W(FREQ_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .freq_code(freq_code), .point_idx(point_idx), .settling(settling),
  .sampling(sampling), .point_done(point_done), .sweep_done(sweep_done)
);

// File: tb/freq_sweep_seq_test.sv
`timescale 1ns/1ps
module freq_sweep_seq_test;
  localparam int NS = 1024;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_code = '0;
  logic exc_tick = 1'b0, smp_valid = 1'b0;
  logic [15:0] dft_re = '0, dft_im = '0;
  logic [23:0] freq_code;
  logic [8:0] point_idx;
  logic settling, sampling, point_done, sweep_done;
  logic [15:0] res_re, res_im;
  int n_chk = 0, n_bad = 0;
  logic [23:0] exp_f;

  always #4 clk = ~clk;

  freq_sweep_seq #(.NSAMP(NS)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .exc_tick(exc_tick),
    .smp_valid(smp_valid), .dft_re(dft_re), .dft_im(dft_im),
    .freq_code(freq_code), .point_idx(point_idx), .settling(settling),
    .sampling(sampling), .point_done(point_done), .sweep_done(sweep_done),
    .res_re(res_re), .res_im(res_im)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [23:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); exc_tick = 1'b1;
    @(negedge clk); exc_tick = 1'b0;
    @(negedge clk);
  endtask

  function automatic int tgt(input logic [15:0] w);
    int m;
    case (w[10:9])
      2'b01: m = 2;
      2'b11: m = 4;
      default: m = 1;
    endcase
    return int'(w[8:0]) * m;
  endfunction

  task automatic settle_chk(input string tag, input int t);
    if (t > 0) begin
      for (int i = 0; i < t - 1; i++) tick();
      repeat (3) @(negedge clk);
      check({tag, " waiting"}, {settling, sampling}, 2'b10);
      tick();
    end
    repeat (2) @(negedge clk);
    check({tag, " window open"}, {settling, sampling}, 2'b01);
  endtask

  task automatic collect(input logic [15:0] re, input logic [15:0] im, input logic exp_sweep);
    dft_re = re; dft_im = im;
    for (int i = 0; i < NS; i++) begin
      @(negedge clk); smp_valid = 1'b1;
      if (i == NS - 2) begin
        @(negedge clk); smp_valid = 1'b0;
        check("R6 still open before last sample", sampling, 1'b1);
      end
    end
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
    check("R6 point_done", {sampling, point_done}, 2'b01);
    check("R6 result", {res_re, res_im}, {re, im});
    check("R7 sweep_done", sweep_done, exp_sweep);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset outputs", {freq_code, point_idx, settling, sampling, point_done, sweep_done}, '0);
    rst = 1'b0;
    wr(2'd0, 24'h123456);
    wr(2'd1, 24'h00014F);
    wr(2'd2, 24'h00FE02);
    wr(2'd3, 24'h00F803);
    cmd(2'd2);
    check("R3 step before begin ignored", {freq_code, settling}, '0);
    cmd(2'd3);
    check("R8 repeat before begin ignored", settling, 1'b0);

    cmd(2'd1);
    exp_f = 24'h123456;
    check("R2 begin load", {freq_code, point_idx, settling}, {exp_f, 9'd0, 1'b1});
    settle_chk("R4 x1 high bits ignored", tgt(16'hF803));
    collect(16'h1111, 16'h2222, 1'b0);

    repeat (3) tick();
    check("R10 tick outside settle", {settling, sampling}, 2'b00);

    wr(2'd3, 24'h000203);
    cmd(2'd2);
    exp_f = exp_f + 24'h00014F;
    check("R3 step add", {freq_code, point_idx, settling}, {exp_f, 9'd1, 1'b1});
    settle_chk("R4 x2", tgt(16'h0203));
    // restart wins while the window is open
    @(negedge clk); smp_valid = 1'b1; cmd_valid = 1'b1; cmd_code = 2'd3;
    @(negedge clk); smp_valid = 1'b0; cmd_valid = 1'b0;
    check("R8 repeat mid window", {freq_code, point_idx, settling}, {exp_f, 9'd1, 1'b1});
    settle_chk("R8 full delay again", tgt(16'h0203));
    collect(16'h3333, 16'h4444, 1'b0);

    wr(2'd3, 24'h000403);
    cmd(2'd3);
    check("R8 repeat keep", {freq_code, point_idx, settling, point_done}, {exp_f, 9'd1, 2'b10});
    settle_chk("R4 reserved as x1", tgt(16'h0403));
    collect(16'h5555, 16'h6666, 1'b0);

    wr(2'd1, 24'hFFFFF0);
    wr(2'd3, 24'h000603);
    cmd(2'd2);
    exp_f = exp_f + 24'hFFFFF0;
    check("R3 step wrap", {freq_code, point_idx}, {exp_f, 9'd2});
    settle_chk("R4 x4", tgt(16'h0603));
    collect(16'hA5A5, 16'h5A5A, 1'b1);
    check("R5 count bits 8..0 only", point_idx, 9'd2);

    cmd(2'd2);
    check("R7 step after sweep ignored",
          {freq_code, point_idx, settling, point_done, sweep_done}, {exp_f, 9'd2, 3'b011});
    @(negedge clk); smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
    check("R10 sample outside window", {res_re, sampling}, {16'hA5A5, 1'b0});

    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 reset again", {freq_code, point_idx, point_done, sweep_done}, '0);
    cmd(2'd1);
    check("R9 start kept over reset", freq_code, 24'h123456);
    settle_chk("R9 settle word kept", tgt(16'h0603));
    collect(16'h0F0F, 16'hF0F0, 1'b0);
    cmd(2'd2);
    check("R9 step kept over reset", freq_code, 24'h123446);

    wr(2'd3, 24'h000600);
    cmd(2'd3);
    settle_chk("R4 zero count", 0);
    collect(16'h1234, 16'h4321, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule